// File: doc/BRIEF.md
# Acknowledged Retransmit Path Selector

This block is the sending end of a link built from several parallel network paths. A producer hands it one message at a time through a valid/ready handshake. The block launches the message on a chosen path together with a one-bit alternating sequence tag, then waits a fixed number of cycles for the receiver to acknowledge that tag. A matching acknowledgement retires the message. When the wait runs out, the block launches the same message again, this time on the next path in round-robin order. Because every retry moves to a different path, a single broken path cannot block delivery.

The path that carried the most recent acknowledged message is remembered, and the next message is tried on it first. After a configurable number of launches without an acknowledgement, the message is dropped and a one-cycle error pulse is raised. A one-cycle completion pulse marks success. The block also reports the number of the current attempt. Acknowledgements that carry a stale tag, or that arrive while nothing is outstanding, are ignored.

Top module: `retx_path_sel`

## Requirements
- R1: While reset is asserted, and after it is released, msg_ready is 1 and link_send, msg_done and msg_error are 0. attempt_no reads 0 and the first message uses tag 0 on path 0.
- R2: A message is accepted only when msg_ready is 1, which holds only while the block is idle. On acceptance, link_send is 1 in the next cycle and carries the accepted data. Offers made while the block is busy are not taken, and they do not change the data being resent.
- R3: An acknowledgement with ack_valid=1 and ack_tag equal to the outstanding tag, arriving in any cycle of the wait window, raises msg_done in the next cycle for exactly one cycle. No further launch of that message follows.
- R4: The wait window is TIMEOUT_CYC cycles long and starts in the cycle after a launch. If no valid acknowledgement arrives, the next launch occurs exactly TIMEOUT_CYC+1 cycles after the previous one. An acknowledgement in the last cycle of the window is still accepted.
- R5: Each retry moves link_sel to (previous path + 1) modulo NUM_PATHS, so a retry never reuses the path that just failed.
- R6: The first launch of a new message uses the path of the most recent acknowledged message. A failed message does not change this remembered path.
- R7: If MAX_TRIES launches of a message all time out, msg_error is 1 for one cycle, TIMEOUT_CYC+1 cycles after the last launch. The message is dropped without another launch, and the block returns to idle.
- R8: An acknowledgement whose tag differs from the outstanding tag, or one that arrives while the block is not waiting, has no effect: no msg_done, and the retry timing is unchanged.
- R9: The tag stays the same across all retries of a message. It inverts once each message ends, whether by completion or by failure.
- R10: attempt_no shows 1 during the first launch of a message and increases by 1 with each retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_valid | input | 1 | Producer offers a message |
| msg_ready | output | 1 | Block can accept a message (idle) |
| msg_data | input | DATA_W | Message payload |
| link_send | output | 1 | One-cycle launch strobe toward the paths |
| link_sel | output | PATH_W | Index of the path used for the launch |
| link_data | output | DATA_W | Payload of the launch |
| link_tag | output | 1 | Alternating sequence tag of the launch |
| ack_valid | input | 1 | Acknowledgement strobe from the receiver |
| ack_tag | input | 1 | Tag carried by the acknowledgement |
| msg_done | output | 1 | One-cycle pulse: message acknowledged |
| msg_error | output | 1 | One-cycle pulse: message dropped after MAX_TRIES |
| attempt_no | output | TRY_W | Number of the current attempt |

## Verification
Each result has a fixed due cycle. A launch is due one cycle after the handshake. A completion pulse is due one cycle after a matching acknowledgement. A retry is due exactly TIMEOUT_CYC+1 cycles after the previous launch, and the error pulse the same distance after the last launch. The bench drives inputs on falling edges and reads outputs on the next falling edge. It measures every interval against a free-running cycle counter, so a launch that is early or late by a single cycle fails its check. Quiet windows that are longer than a full wait window confirm that no launch follows a completion, a failure or an ignored acknowledgement.

// File: rtl/retx_pkg.sv
package retx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_DONE = 3'd3,
    ST_FAIL = 3'd4
  } retx_state_e;

endpackage

// File: rtl/retx_rst_sync.sv
module retx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/retx_timer.sv
module retx_timer #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // load wins over countdown; countdown stops at zero
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == '0);

  // R4: counter never exceeds the window length
  assert_timer_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);

  // R4: a load always yields a full window on the next cycle
  assert_timer_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired || (TIMEOUT_CYC == 1));

endmodule

// File: rtl/retx_path_ptr.sv
module retx_path_ptr #(
  parameter int unsigned NUM_PATHS = 4,
  parameter int unsigned PATH_W    = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic              success,
  output logic [PATH_W-1:0] cur_path
);

  localparam logic [PATH_W-1:0] LAST_IDX = PATH_W'(NUM_PATHS - 1);

  logic [PATH_W-1:0] cur_q, cur_d, good_q, step_path;
  logic              cur_en;

  generate
    if ((NUM_PATHS & (NUM_PATHS - 1)) == 0) begin : g_pow2_wrap
      assign step_path = cur_q + 1'b1;
    end else begin : g_cmp_wrap
      assign step_path = (cur_q == LAST_IDX) ? '0 : cur_q + 1'b1;
    end
  endgenerate

  always_comb begin
    cur_en = 1'b0;
    cur_d  = cur_q;
    if (start) begin
      cur_en = 1'b1;
      cur_d  = good_q;
    end else if (advance) begin
      cur_en = 1'b1;
      cur_d  = step_path;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       good_q <= '0;
    else if (success) good_q <= cur_q;
  end

  assign cur_path = cur_q;

  // R5: index stays inside the path range
  assert_path_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= LAST_IDX);

  // R5: a retry always lands on another path
  assert_retry_new_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start && NUM_PATHS > 1) |=> cur_q != $past(cur_q));

  // R6: a new message starts on the remembered path
  assert_start_on_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !success) |=> cur_q == $past(good_q));

endmodule

// File: rtl/retx_ctrl.sv
module retx_ctrl
  import retx_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 3,
  parameter int unsigned TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             ack_valid,
  input  logic             ack_tag,
  input  logic             expired,
  output logic             in_ready,
  output logic             accept,
  output logic             send,
  output logic             waiting,
  output logic             retry,
  output logic             success,
  output logic             done,
  output logic             fail,
  output logic             tag,
  output logic [TRY_W-1:0] tries
);

  localparam logic [TRY_W-1:0] TRY_LIMIT = TRY_W'(MAX_TRIES);

  retx_state_e      state_q, state_d;
  logic             tag_q, tag_en;
  logic [TRY_W-1:0] try_q, try_d;
  logic             try_en;
  logic             ack_hit, at_limit;

  assign ack_hit  = (state_q == ST_WAIT) && ack_valid && (ack_tag == tag_q);
  assign at_limit = (try_q == TRY_LIMIT);

  // next-state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_SEND;
      ST_SEND: state_d = ST_WAIT;
      ST_WAIT: begin
        if (ack_hit)       state_d = ST_DONE;
        else if (expired)  state_d = at_limit ? ST_FAIL : ST_SEND;
      end
      ST_DONE: state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // attempt counter: 1 on accept, +1 on each retry
  always_comb begin
    try_en = 1'b0;
    try_d  = try_q;
    if (accept) begin
      try_en = 1'b1;
      try_d  = TRY_W'(1);
    end else if (retry) begin
      try_en = 1'b1;
      try_d  = try_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      try_q <= '0;
    else if (try_en) try_q <= try_d;
  end

  // tag flips once per finished message
  assign tag_en = (state_q == ST_DONE) || (state_q == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= 1'b0;
    else if (tag_en) tag_q <= ~tag_q;
  end

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_ready && in_valid;
  assign send     = (state_q == ST_SEND);
  assign waiting  = (state_q == ST_WAIT);
  assign retry    = waiting && !ack_hit && expired && !at_limit;
  assign success  = ack_hit;
  assign done     = (state_q == ST_DONE);
  assign fail     = (state_q == ST_FAIL);
  assign tag      = tag_q;
  assign tries    = try_q;

  // R2: handshake leads to a first launch next cycle
  assert_accept_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (send && tries == TRY_W'(1)));

  // R3: matching acknowledgement retires without relaunch
  assert_ack_retires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    success |=> (done && !send));

  // R4: timeout below the limit causes a launch next cycle
  assert_resend_after_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && expired && !ack_valid && !at_limit) |=> send);

  // R7: error only after the full number of attempts
  assert_fail_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (tries == TRY_LIMIT && !done));

  // R8: wrong-tag acknowledgement leaves the wait untouched
  assert_stale_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ack_valid && ack_tag != tag && !expired) |=> waiting);

  // R9: tag inverts after each finished message
  assert_tag_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> (tag != $past(tag)));

  // R9: tag constant while a message is in flight
  assert_tag_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (send || waiting) |=> $stable(tag));

endmodule

// File: rtl/retx_path_sel.sv
module retx_path_sel #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_PATHS   = 4,
  parameter int unsigned TIMEOUT_CYC = 12,
  parameter int unsigned MAX_TRIES   = 3,
  parameter int unsigned PATH_W      = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1,
  parameter int unsigned TRY_W       = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [DATA_W-1:0] msg_data,
  output logic              link_send,
  output logic [PATH_W-1:0] link_sel,
  output logic [DATA_W-1:0] link_data,
  output logic              link_tag,
  input  logic              ack_valid,
  input  logic              ack_tag,
  output logic              msg_done,
  output logic              msg_error,
  output logic [TRY_W-1:0]  attempt_no
);

  logic              rst_sync_n;
  logic              accept, waiting, retry, success, expired;
  logic [DATA_W-1:0] payload_q;

  retx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  retx_ctrl #(
    .MAX_TRIES (MAX_TRIES),
    .TRY_W     (TRY_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (msg_valid),
    .ack_valid (ack_valid),
    .ack_tag   (ack_tag),
    .expired   (expired),
    .in_ready  (msg_ready),
    .accept    (accept),
    .send      (link_send),
    .waiting   (waiting),
    .retry     (retry),
    .success   (success),
    .done      (msg_done),
    .fail      (msg_error),
    .tag       (link_tag),
    .tries     (attempt_no)
  );

  retx_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (link_send),
    .run     (waiting),
    .expired (expired)
  );

  retx_path_ptr #(
    .NUM_PATHS (NUM_PATHS),
    .PATH_W    (PATH_W)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .advance  (retry),
    .success  (success),
    .cur_path (link_sel)
  );

  // payload holding register, written only on handshake
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  payload_q <= '0;
    else if (accept)  payload_q <= msg_data;
  end

  assign link_data = payload_q;

  // R2: payload is frozen while the message is outstanding
  assert_payload_held_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!msg_ready) |=> $stable(link_data) || $past(msg_ready));

  // R3: completion and error never coincide with a launch
  assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({link_send, msg_done, msg_error}));

endmodule

// File: tb/retx_path_sel_tb.sv
module retx_path_sel_tb_top;

  localparam int DW = 16;
  localparam int NP = 4;
  localparam int T  = 12;
  localparam int MT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          msg_valid, msg_ready;
  logic [DW-1:0] msg_data;
  logic          link_send;
  logic [1:0]    link_sel;
  logic [DW-1:0] link_data;
  logic          link_tag;
  logic          ack_valid, ack_tag;
  logic          msg_done, msg_error;
  logic [1:0]    attempt_no;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  retx_path_sel #(
    .DATA_W(DW), .NUM_PATHS(NP), .TIMEOUT_CYC(T), .MAX_TRIES(MT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .link_send(link_send), .link_sel(link_sel), .link_data(link_data),
    .link_tag(link_tag), .ack_valid(ack_valid), .ack_tag(ack_tag),
    .msg_done(msg_done), .msg_error(msg_error), .attempt_no(attempt_no)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic offer(input logic [DW-1:0] d);
    chk("R2", "ready before offer", 32'(msg_ready), 1);
    msg_valid = 1'b1;
    msg_data  = d;
    step();
    msg_valid = 1'b0;
  endtask

  task automatic give_ack(input logic t);
    ack_valid = 1'b1;
    ack_tag   = t;
    step();
    ack_valid = 1'b0;
  endtask

  task automatic next_tx(output int dt);
    int s = cyc;
    do step(); while (!link_send && (cyc - s) < 4 * T);
    dt = cyc - s;
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (link_send) seen++;
    end
    chk(req, "no launch in quiet window", 32'(seen), 0);
  endtask

  task automatic launch_chk(input string req, input int path, input logic tg,
                            input logic [DW-1:0] d, input int tr);
    chk(req, "launch strobe", 32'(link_send), 1);
    chk(req, "launch path", 32'(link_sel), 32'(path));
    chk("R9", "launch tag", 32'(link_tag), 32'(tg));
    chk("R2", "launch data", 32'(link_data), 32'(d));
    chk("R10", "attempt number", 32'(attempt_no), 32'(tr));
  endtask

  task automatic t_reset();
    chk("R1", "ready in reset", 32'(msg_ready), 1);
    chk("R1", "send in reset", 32'(link_send), 0);
    chk("R1", "done in reset", 32'(msg_done), 0);
    chk("R1", "error in reset", 32'(msg_error), 0);
    chk("R1", "attempt in reset", 32'(attempt_no), 0);
  endtask

  task automatic t_clean();
    offer(16'hA001);
    launch_chk("R1", 0, 1'b0, 16'hA001, 1);
    chk("R2", "ready low while busy", 32'(msg_ready), 0);
    step();
    give_ack(1'b0);
    chk("R3", "done after ack", 32'(msg_done), 1);
    step();
    chk("R3", "done one cycle", 32'(msg_done), 0);
    chk("R3", "idle after done", 32'(msg_ready), 1);
    quiet(T + 4, "R3");
  endtask

  task automatic t_retry_busy();
    int dt, s;
    offer(16'hA002);
    launch_chk("R6", 0, 1'b1, 16'hA002, 1);
    s = cyc;
    step();
    msg_valid = 1'b1;
    msg_data  = 16'hBEEF;
    chk("R2", "ready low in wait", 32'(msg_ready), 0);
    next_tx(dt);
    msg_valid = 1'b0;
    chk("R4", "retry interval", 32'(cyc - s), 32'(T + 1));
    launch_chk("R5", 1, 1'b1, 16'hA002, 2);
    step();
    give_ack(1'b1);
    chk("R3", "done after retry ack", 32'(msg_done), 1);
    step();
  endtask

  task automatic t_reuse_path();
    offer(16'hA003);
    launch_chk("R6", 1, 1'b0, 16'hA003, 1);
    step();
    give_ack(1'b0);
    chk("R3", "done", 32'(msg_done), 1);
    step();
  endtask

  task automatic t_stale_ack();
    int dt, s;
    give_ack(1'b1);
    chk("R8", "idle ack no done", 32'(msg_done), 0);
    chk("R8", "idle ack keeps ready", 32'(msg_ready), 1);
    offer(16'hA004);
    launch_chk("R6", 1, 1'b1, 16'hA004, 1);
    s = cyc;
    step();
    give_ack(1'b0);
    chk("R8", "wrong tag no done", 32'(msg_done), 0);
    chk("R8", "wrong tag no launch", 32'(link_send), 0);
    next_tx(dt);
    chk("R8", "retry interval unchanged", 32'(cyc - s), 32'(T + 1));
    launch_chk("R5", 2, 1'b1, 16'hA004, 2);
    step();
    give_ack(1'b1);
    chk("R3", "done", 32'(msg_done), 1);
    step();
  endtask

  task automatic t_last_cycle_ack();
    offer(16'hA005);
    launch_chk("R6", 2, 1'b0, 16'hA005, 1);
    repeat (T) step();
    give_ack(1'b0);
    chk("R4", "ack in last window cycle done", 32'(msg_done), 1);
    chk("R4", "ack in last window no launch", 32'(link_send), 0);
    step();
  endtask

  task automatic t_give_up();
    int dt, s;
    offer(16'hA006);
    launch_chk("R6", 2, 1'b1, 16'hA006, 1);
    s = cyc;
    next_tx(dt);
    chk("R4", "retry 1 interval", 32'(cyc - s), 32'(T + 1));
    launch_chk("R5", 3, 1'b1, 16'hA006, 2);
    s = cyc;
    next_tx(dt);
    chk("R4", "retry 2 interval", 32'(cyc - s), 32'(T + 1));
    launch_chk("R5", 0, 1'b1, 16'hA006, 3);
    s = cyc;
    repeat (T) begin
      step();
      if (link_send) chk("R7", "launch beyond limit", 1, 0);
    end
    step();
    chk("R7", "error timing", 32'(cyc - s), 32'(T + 1));
    chk("R7", "error pulse", 32'(msg_error), 1);
    chk("R7", "no done on error", 32'(msg_done), 0);
    chk("R7", "no launch on error", 32'(link_send), 0);
    step();
    chk("R7", "error one cycle", 32'(msg_error), 0);
    chk("R7", "idle after error", 32'(msg_ready), 1);
    quiet(T + 4, "R7");
  endtask

  task automatic t_after_fail();
    offer(16'hA007);
    launch_chk("R6", 2, 1'b0, 16'hA007, 1);
    step();
    give_ack(1'b0);
    chk("R3", "done", 32'(msg_done), 1);
    step();
    give_ack(1'b0);
    chk("R8", "duplicate ack ignored", 32'(msg_done), 0);
    quiet(T + 2, "R8");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    msg_valid = 1'b0;
    msg_data  = '0;
    ack_valid = 1'b0;
    ack_tag   = 1'b0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_clean();
    t_retry_busy();
    t_reuse_path();
    t_stale_ack();
    t_last_cycle_ack();
    t_give_up();
    t_after_fail();
    summary();
    $finish;
  end

endmodule